// File: doc/BRIEF.md
# Table Jump Target Fetch Unit

This block works out where a compressed table-jump instruction lands. The core hands it an entry index together with the current value of the jump-table control register, the active register width (32 or 64 bits) and a permission code from the state-enable logic. The block decides whether the jump may proceed. It then forms the address of the table entry and performs one instruction-side read over a request/acknowledge port. It returns either the target address with its lowest bit cleared or an exception with a cause code.

The control register holds the table base in its upper bits. Its low six bits form a mode field, and only the value zero is legal there. Entries are four bytes apart at width 32 and eight bytes apart at width 64. Decoding the instruction, writing the link register and steering the program counter belong to the surrounding pipeline.

Top module: `tbljmp_fetch`

## Requirements
- R1: A permission code other than 00 on `tbl_perm` at acceptance raises `exc` without any read. Code 10 gives cause 22 (virtual instruction). Codes 01 and 11 give cause 2 (illegal instruction).
- R2: When the permission code is 00 and the control register's bits [5:0] are non-zero, `exc` is raised with cause 2 and no read is issued. The permission check takes priority over the mode check.
- R3: At width 32 (`xlen64`=0) the read address is (control value with bits [5:0] cleared) + index*4, truncated to 32 bits and zero-extended, and `mem_dword` is 0.
- R4: At width 64 (`xlen64`=1) the read address is (control value with bits [5:0] cleared) + index*8, taken modulo 2^64, and `mem_dword` is 1.
- R5: `target` equals the read data with bit 0 cleared. At width 32 only bits [31:0] of the read data are used, and bits [63:32] of `target` are zero.
- R6: A read that completes with `mem_fault`=1 ends in `exc` with cause 1 (instruction access fault) and no `done`.
- R7: Each accepted request yields exactly one single-cycle pulse on either `done` or `exc`, never both. A rejected request pulses `exc` in the cycle after acceptance. A read result pulses in the cycle after the cycle in which `mem_ack` is seen.
- R8: `busy` is high from the cycle after a request is accepted for a read until `mem_ack` is seen. A `req_valid` that arrives while `busy` is high is ignored. A request is accepted in any cycle in which `busy` is low.
- R9: `mem_req` is high exactly while `busy` is high, and `mem_addr` and `mem_dword` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a table jump resolution |
| req_index | input | 8 | Table entry index |
| tbl_csr | input | 64 | Jump-table control register value (base in upper bits, mode in [5:0]) |
| xlen64 | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| tbl_perm | input | 2 | State-enable permission code: 00 allowed, 01/11 illegal, 10 virtual |
| busy | output | 1 | A table read is outstanding |
| mem_req | output | 1 | Instruction-side read request |
| mem_addr | output | 64 | Read address |
| mem_dword | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| mem_ack | input | 1 | Read completion |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_fault | input | 1 | Read failed, valid with `mem_ack` |
| done | output | 1 | Single-cycle pulse: `target` is valid |
| target | output | 64 | Resolved jump target |
| exc | output | 1 | Single-cycle pulse: `exc_cause` is valid |
| exc_cause | output | 5 | Exception cause code |

## Verification
The bench builds the block with its default parameters: a 64-bit address path, an 8-bit index and a 6-bit mode field. With these values index 255 reaches 2040 bytes past the base, and a base near the top of either the 32-bit or the 64-bit range makes the entry address wrap. The bench also sets the upper register bits while running at width 32, which checks the truncation and the zero extension of the target. The memory model varies its acknowledge latency from zero to three cycles and faults on one address window. The bench also holds `req_valid` high across whole transactions, which tests the ignore-while-busy rule and back-to-back acceptance in the result cycle.

// File: rtl/tjt_pkg.sv
package tjt_pkg;

    localparam int CAUSE_IFAULT  = 1;
    localparam int CAUSE_ILLEGAL = 2;
    localparam int CAUSE_VIRT    = 22;

    typedef enum logic [1:0] {
        PERM_OK        = 2'b00,
        PERM_DENY      = 2'b01,
        PERM_DENY_VIRT = 2'b10,
        PERM_RSVD      = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        V_FETCH,
        V_ILLEGAL,
        V_VIRT
    } verdict_e;

    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } state_e;

    function automatic int cause_of(verdict_e v);
        case (v)
            V_VIRT:  return CAUSE_VIRT;
            default: return CAUSE_ILLEGAL;
        endcase
    endfunction

endpackage

// File: rtl/tjt_gate.sv
module tjt_gate
    import tjt_pkg::*;
#(
    parameter int MODE_W = 6
) (
    input  logic [1:0]        perm,
    input  logic [MODE_W-1:0] mode,
    output verdict_e          verdict
);
    // Permission outranks the mode field.
    always_comb begin
        case (perm_e'(perm))
            PERM_OK:        verdict = (mode == '0) ? V_FETCH : V_ILLEGAL;
            PERM_DENY_VIRT: verdict = V_VIRT;
            default:        verdict = V_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/tjt_addr_gen.sv
module tjt_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 8,
    parameter int MODE_W = 6
) (
    input  logic [ADDR_W-1:0] csr,
    input  logic [IDX_W-1:0]  idx,
    input  logic              x64,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((64'd1 << MODE_W) - 64'd1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        base   = csr & BASE_MASK;
        offset = x64 ? (ADDR_W'(idx) << 3) : (ADDR_W'(idx) << 2);
        sum    = base + offset;
    end

    generate
        if (ADDR_W > 32) begin : g_wide
            localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(64'hFFFF_FFFF);
            assign addr = x64 ? sum : (sum & LOW_MASK);
        end else begin : g_narrow
            assign addr = sum;
        end
    endgenerate
endmodule

// File: rtl/tjt_fetch_ctl.sv
module tjt_fetch_ctl
    import tjt_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  verdict_e           verdict,
    input  logic               x64,
    input  logic [ADDR_W-1:0]  entry_addr,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_dword,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata,
    input  logic               mem_fault,
    output logic               done,
    output logic [ADDR_W-1:0]  target,
    output logic               exc,
    output logic [CAUSE_W-1:0] exc_cause
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(64'hFFFF_FFFF);

    state_e              state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                x64_q;
    logic                done_q;
    logic                exc_q;
    logic [CAUSE_W-1:0]  cause_q;
    logic [ADDR_W-1:0]   target_q;
    logic [ADDR_W-1:0]   shaped;
    logic                accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        shaped = x64_q ? mem_rdata : (mem_rdata & LOW_MASK);
        shaped[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            x64_q    <= 1'b0;
            done_q   <= 1'b0;
            exc_q    <= 1'b0;
            cause_q  <= '0;
            target_q <= '0;
        end else begin
            done_q <= 1'b0;
            exc_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (verdict == V_FETCH) begin
                            state_q <= ST_FETCH;
                            addr_q  <= entry_addr;
                            x64_q   <= x64;
                        end else begin
                            exc_q   <= 1'b1;
                            cause_q <= CAUSE_W'(cause_of(verdict));
                        end
                    end
                end
                default: begin
                    if (mem_ack) begin
                        state_q <= ST_IDLE;
                        if (mem_fault) begin
                            exc_q   <= 1'b1;
                            cause_q <= CAUSE_W'(CAUSE_IFAULT);
                        end else begin
                            done_q   <= 1'b1;
                            target_q <= shaped;
                        end
                    end
                end
            endcase
        end
    end

    assign busy      = (state_q == ST_FETCH);
    assign mem_req   = busy;
    assign mem_addr  = addr_q;
    assign mem_dword = x64_q;
    assign done      = done_q;
    assign exc       = exc_q;
    assign target    = target_q;
    assign exc_cause = cause_q;

    // R1 / R2: a rejected request never starts a read and reports at once
    a_r1_no_fetch_on_reject: assert property (@(posedge clk) disable iff (rst)
        accept && (verdict != V_FETCH) |=> !mem_req && exc);

    // R7: one result kind per cycle
    a_r7_single_result: assert property (@(posedge clk) disable iff (rst)
        !(done && exc));

    // R9: request and address hold until acknowledged
    a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_dword));

    // R5: bit 0 of the target is always clear
    a_r5_lsb_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> !target[0]);

    // R5: narrow-width targets are zero-extended
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (rst)
        done && !x64_q |-> (target & ~LOW_MASK) == '0);

    // R8: the read finishes in the cycle after acknowledge
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !busy && (done || exc));
endmodule

// File: rtl/tbljmp_fetch.sv
module tbljmp_fetch
    import tjt_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int IDX_W   = 8,
    parameter int MODE_W  = 6,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [ADDR_W-1:0]  tbl_csr,
    input  logic               xlen64,
    input  logic [1:0]         tbl_perm,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_dword,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata,
    input  logic               mem_fault,
    output logic               done,
    output logic [ADDR_W-1:0]  target,
    output logic               exc,
    output logic [CAUSE_W-1:0] exc_cause
);
    verdict_e          verdict;
    logic [ADDR_W-1:0] entry_addr;

    tjt_gate #(.MODE_W(MODE_W)) u_gate (
        .perm    (tbl_perm),
        .mode    (tbl_csr[MODE_W-1:0]),
        .verdict (verdict)
    );

    tjt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MODE_W(MODE_W)) u_addr (
        .csr  (tbl_csr),
        .idx  (req_index),
        .x64  (xlen64),
        .addr (entry_addr)
    );

    tjt_fetch_ctl #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .verdict    (verdict),
        .x64        (xlen64),
        .entry_addr (entry_addr),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_dword  (mem_dword),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_fault  (mem_fault),
        .done       (done),
        .target     (target),
        .exc        (exc),
        .exc_cause  (exc_cause)
    );

    // R8: outstanding read implies an active request on the port
    a_r8_busy_req: assert property (@(posedge clk) disable iff (rst)
        busy |-> mem_req);
endmodule

// File: tb/tbljmp_fetch_tb_top.sv
module tbljmp_fetch_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_index = '0;
    logic [63:0] tbl_csr = '0;
    logic        xlen64 = 1'b0;
    logic [1:0]  tbl_perm = '0;
    logic        busy, mem_req, mem_dword, done, exc;
    logic [63:0] mem_addr, target;
    logic [4:0]  exc_cause;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wait_cnt = 0;
    bit finished = 0;

    // reference model state
    bit          m_busy = 0;
    logic [63:0] m_addr = '0;
    bit          m_x64 = 0;
    bit          e_done = 0, e_exc = 0;
    logic [63:0] e_target = '0;
    int          e_cause = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbljmp_fetch dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .tbl_csr(tbl_csr), .xlen64(xlen64), .tbl_perm(tbl_perm),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .done(done), .target(target), .exc(exc), .exc_cause(exc_cause)
    );

    function automatic logic [63:0] mem_data(logic [63:0] a);
        return {~a[31:0], a[31:0] ^ 32'h1357_9BDF} | 64'd1;
    endfunction

    function automatic bit mem_bad(logic [63:0] a);
        return a[15:12] == 4'hF;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            m_busy = 0; e_done = 0; e_exc = 0; wait_cnt = 0;
            mem_ack <= 1'b0;
        end else begin
            check("R7 done", done, e_done);
            check("R7 exc", exc, e_exc);
            check("R8 busy", busy, m_busy);
            check("R9 mem_req", mem_req, m_busy);
            if (e_done) check("R5 target", target, e_target);
            if (e_exc) begin
                if (e_cause == 1) check("R6 cause", exc_cause, 64'(e_cause));
                else              check("R1/R2 cause", exc_cause, 64'(e_cause));
            end
            if (m_busy) begin
                if (m_x64) check("R4 addr", mem_addr, m_addr);
                else       check("R3 addr", mem_addr, m_addr);
                check("R3/R4 dword", mem_dword, m_x64);
            end
            #1;
            // memory responder
            mem_ack = 1'b0; mem_fault = 1'b0;
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_data(mem_addr);
                    mem_fault = mem_bad(mem_addr);
                    wait_cnt = 0;
                end else wait_cnt++;
            end
            // reference model advance
            e_done = 0; e_exc = 0;
            if (m_busy) begin
                if (mem_ack) begin
                    m_busy = 0;
                    if (mem_bad(m_addr)) begin
                        e_exc = 1; e_cause = 1;
                    end else begin
                        e_done = 1;
                        e_target = m_x64 ? mem_data(m_addr) : {32'h0, mem_data(m_addr)[31:0]};
                        e_target[0] = 1'b0;
                    end
                end
            end else if (req_valid) begin
                if (tbl_perm == 2'b10) begin
                    e_exc = 1; e_cause = 22;
                end else if (tbl_perm != 2'b00 || tbl_csr[5:0] != 6'd0) begin
                    e_exc = 1; e_cause = 2;
                end else begin
                    m_busy = 1;
                    m_x64 = xlen64;
                    m_addr = (tbl_csr & ~64'h3F) + (xlen64 ? (64'(req_index) << 3) : (64'(req_index) << 2));
                    if (!xlen64) m_addr[63:32] = 32'h0;
                end
            end
        end
    end

    task automatic issue(logic [7:0] idx, logic [63:0] csr, bit x64, logic [1:0] perm, int hold);
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; tbl_csr = csr; xlen64 = x64; tbl_perm = perm;
        repeat (hold) @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R7, R8) covered by per-cycle comparison
        lat = 1; issue(8'd5, 64'h0000_0000_8000_0000, 0, 2'b00, 1);   // R3 R5
        lat = 0; issue(8'd255, 64'h0000_0001_0000_0000, 1, 2'b00, 1); // R4
        lat = 2; issue(8'd255, 64'hFFFF_FFFF_FFFF_FF00, 1, 2'b00, 1); // R4 wrap
        lat = 1; issue(8'h20, 64'hAAAA_0000_FFFF_FFC0, 0, 2'b00, 1);  // R3 wrap, R5 zero-ext
        issue(8'd3, 64'h0000_0000_0001_0001, 1, 2'b00, 1);            // R2 mode
        issue(8'd3, 64'h0000_0000_0001_0000, 1, 2'b01, 1);            // R1 illegal
        issue(8'd3, 64'h0000_0000_0001_0000, 1, 2'b10, 1);            // R1 virtual
        issue(8'd3, 64'h0000_0000_0001_0000, 0, 2'b11, 1);            // R1 reserved
        issue(8'd3, 64'h0000_0000_0001_0005, 1, 2'b10, 1);            // R2 priority
        issue(8'd1, 64'h0000_0000_0000_F000, 1, 2'b00, 1);            // R6 fault
        issue(8'd2, 64'h0000_0000_0000_F000, 0, 2'b00, 1);            // R6 fault narrow
        lat = 3; issue(8'd7, 64'h0000_0000_2000_0040, 1, 2'b00, 10);  // R8 ignore while busy
        lat = 0; issue(8'd9, 64'h0000_0000_2000_0000, 0, 2'b00, 6);   // R8 back-to-back
        lat = 2; issue(8'd0, 64'h1234_5678_9ABC_DE00, 1, 2'b00, 1);   // R9 hold
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule